// File: doc/BRIEF.md
# Event-Triggered Deadline Actor Controller

This block sequences one run of a computing actor each time an event arrives. It does not transfer data and does not compute. It drives four single-cycle strobes. `get_input` tells an input register to capture operands. `start_spu` launches a separate compute unit. `produce_output` tells an output register to publish results. `deadline_violation` reports that results were not ready when time ran out. The compute unit reports back through a level `ready` input. Time is measured by counting `tick` pulses from a free-running time base.

The mode is captured when the start event is accepted, and there are three modes. In the bounded mode, the start event launches the computation at once. Output is released when the tick count reaches the captured deadline. In the free mode, output is released as soon as the compute unit reports ready, with no time limit. This is the behaviour of an intermediate stage of a chain. The terminal mode serves the last stage of a multi-stage transaction. The global transaction start only arms the tick counter. A later message-arrival trigger launches the computation. Output is held back until the end-to-end deadline that the stage inherits.

The states are IDLE, WAIT_DL (bounded, computing), WAIT_RDY (free, computing), ARMED (terminal, timer running, waiting for the trigger) and HOLD (terminal, computing, holding output). The transitions are:
- IDLE→WAIT_DL, IDLE→WAIT_RDY or IDLE→ARMED on `start_evt`.
- WAIT_DL→IDLE and HOLD→IDLE on expiry.
- WAIT_RDY→IDLE on `ready`.
- ARMED→HOLD on `trig_evt`.
- ARMED→IDLE on expiry.

All strobes are Mealy outputs: each is issued in the same cycle as the event that causes it.

Top module: `ea_actor_ctrl`

## Requirements
- R1: After reset all four strobes are low and the controller is idle, so a start event in the first cycle after reset is accepted.
- R2: Mode encoding: 2'b00 is bounded, 2'b01 and 2'b11 are free, and 2'b10 is terminal. In bounded and free mode, a start event accepted in IDLE pulses `get_input` and `start_spu` together in that same cycle.
- R3: In bounded mode the tick count is cleared at the start event, and a tick in that start cycle is not counted. On the tick that makes the count reach the captured deadline, the controller pulses `produce_output` if `ready` is high, or `deadline_violation` if it is low, in that same cycle. It then returns to IDLE.
- R4: In free mode the controller pulses `produce_output` in the first cycle after the launch in which `ready` is high, and then returns to IDLE. A `ready` that is high only in the launch cycle itself is not seen. Free mode never raises `deadline_violation`.
- R5: In terminal mode the start event clears and runs the tick count but issues no strobe. A trigger event in ARMED pulses `get_input` and `start_spu` in that cycle and moves to HOLD.
- R6: In terminal mode, the tick that reaches the deadline while in HOLD pulses `produce_output` if `ready` is high, or `deadline_violation` otherwise, and the controller returns to IDLE. Deadline timing is measured from the start event, not from the trigger.
- R7: In terminal mode, if the deadline is reached while still in ARMED, the controller pulses `deadline_violation` and returns to IDLE. A trigger in that same cycle is ignored and produces no strobe.
- R8: A start event while the controller is busy is ignored: no strobe is issued and the tick count is not restarted. A trigger event in any state other than ARMED is ignored.
- R9: The deadline value and the mode are captured at the accepted start event. Changing them while the controller is busy does not move the completion cycle.
- R10: A captured deadline of zero in bounded or terminal mode expires on the first counted tick.
- R11: `produce_output` and `deadline_violation` are never high together. No strobe stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse, one cycle per time unit |
| start_evt | input | 1 | Start event pulse (transaction start in terminal mode) |
| trig_evt | input | 1 | Message-arrival trigger pulse (terminal mode) |
| ready | input | 1 | Compute unit has finished (level) |
| mode | input | 2 | Mode select, captured at start |
| deadline | input | DL_W | Deadline in ticks, captured at start |
| get_input | output | 1 | Capture-input strobe |
| start_spu | output | 1 | Launch-compute strobe |
| produce_output | output | 1 | Publish-output strobe |
| deadline_violation | output | 1 | Deadline-miss strobe |

## Verification
The bounded mode is run with a tick every cycle and with sparse ticks, and with `ready` either rising before expiry or staying low. This separates the ready-gated release from the miss path, and also exposes a counter that counts cycles instead of ticks. The free mode is run with `ready` present in the launch cycle and with `ready` rising late, which pins down exactly which cycle is used for sampling. The terminal mode is run with an early trigger, no trigger, and a trigger coinciding with expiry. Together these show that the timer starts at the transaction start and that expiry has priority. Busy-time start events, stray triggers, mid-run changes of mode and deadline, and a zero deadline show that the captured values are kept and that extra events are ignored.

// File: rtl/ea_actor_pkg.sv
package ea_actor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_DL  = 3'd1,
        ST_WAIT_RDY = 3'd2,
        ST_ARMED    = 3'd3,
        ST_HOLD     = 3'd4
    } act_state_e;

    typedef enum logic [1:0] {
        RUN_BOUNDED  = 2'b00,
        RUN_FREE     = 2'b01,
        RUN_TERMINAL = 2'b10,
        RUN_FREE_ALT = 2'b11
    } run_mode_e;

    typedef struct packed {
        logic get_in;
        logic spu_go;
        logic publish;
        logic miss;
    } act_strobes_t;

    localparam act_strobes_t STROBES_NONE = '{get_in: 1'b0, spu_go: 1'b0,
                                              publish: 1'b0, miss: 1'b0};

    // Maps the raw mode select to the state entered on an accepted start.
    function automatic act_state_e launch_state(input logic [1:0] sel);
        act_state_e nxt;
        unique case (run_mode_e'(sel))
            RUN_BOUNDED:  nxt = ST_WAIT_DL;
            RUN_TERMINAL: nxt = ST_ARMED;
            RUN_FREE:     nxt = ST_WAIT_RDY;
            RUN_FREE_ALT: nxt = ST_WAIT_RDY;
            default:      nxt = ST_WAIT_RDY;
        endcase
        return nxt;
    endfunction

    // True when the launch itself fires the compute strobes.
    function automatic logic launch_fires(input logic [1:0] sel);
        return run_mode_e'(sel) != RUN_TERMINAL;
    endfunction

endpackage

// File: rtl/ea_tick_timer.sv
module ea_tick_timer #(
    parameter int DL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            tick,
    input  logic [DL_W-1:0] limit_in,
    output logic            expire
);
    localparam int CMP_W = DL_W + 1;
    localparam logic [DL_W-1:0] CNT_MAX = {DL_W{1'b1}};

    logic [DL_W-1:0] count_q;
    logic [DL_W-1:0] limit_q;
    logic [CMP_W-1:0] count_next_ext;
    logic            at_max;

    assign at_max         = (count_q == CNT_MAX);
    assign count_next_ext = {1'b0, count_q} + CMP_W'(1);

    // Captured limit for the current run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (restart) begin
            limit_q <= limit_in;
        end
    end

    // Tick counter, cleared at a run start, saturating at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= '0;
        end else if (tick && !at_max) begin
            count_q <= count_q + DL_W'(1);
        end
    end

    // Expiry on the tick that brings the count up to the limit
    always_comb begin
        expire = 1'b0;
        if (tick && !restart) begin
            expire = (count_next_ext >= {1'b0, limit_q});
        end
    end

endmodule

// File: rtl/ea_actor_fsm.sv
module ea_actor_fsm
    import ea_actor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt,
    input  logic       trig_evt,
    input  logic       ready,
    input  logic [1:0] mode,
    input  logic       expire,
    output logic       timer_restart,
    output act_strobes_t strobes
);
    act_state_e state_q;
    act_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and Mealy strobes
    always_comb begin
        state_d       = state_q;
        strobes       = STROBES_NONE;
        timer_restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_evt) begin
                    timer_restart = 1'b1;
                    state_d       = launch_state(mode);
                    if (launch_fires(mode)) begin
                        strobes.get_in = 1'b1;
                        strobes.spu_go = 1'b1;
                    end
                end
            end
            ST_WAIT_DL: begin
                if (expire) begin
                    state_d = ST_IDLE;
                    if (ready) strobes.publish = 1'b1;
                    else       strobes.miss    = 1'b1;
                end
            end
            ST_WAIT_RDY: begin
                if (ready) begin
                    strobes.publish = 1'b1;
                    state_d         = ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (expire) begin
                    strobes.miss = 1'b1;
                    state_d      = ST_IDLE;
                end else if (trig_evt) begin
                    strobes.get_in = 1'b1;
                    strobes.spu_go = 1'b1;
                    state_d        = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (expire) begin
                    state_d = ST_IDLE;
                    if (ready) strobes.publish = 1'b1;
                    else       strobes.miss    = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/ea_actor_ctrl.sv
module ea_actor_ctrl
    import ea_actor_pkg::*;
#(
    parameter int DL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            start_evt,
    input  logic            trig_evt,
    input  logic            ready,
    input  logic [1:0]      mode,
    input  logic [DL_W-1:0] deadline,
    output logic            get_input,
    output logic            start_spu,
    output logic            produce_output,
    output logic            deadline_violation
);
    logic         restart_w;
    logic         expire_w;
    act_strobes_t strobes_w;

    ea_tick_timer #(
        .DL_W (DL_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart_w),
        .tick     (tick),
        .limit_in (deadline),
        .expire   (expire_w)
    );

    ea_actor_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_evt     (start_evt),
        .trig_evt      (trig_evt),
        .ready         (ready),
        .mode          (mode),
        .expire        (expire_w),
        .timer_restart (restart_w),
        .strobes       (strobes_w)
    );

    assign get_input          = strobes_w.get_in;
    assign start_spu          = strobes_w.spu_go;
    assign produce_output     = strobes_w.publish;
    assign deadline_violation = strobes_w.miss;

endmodule

// File: rtl/ea_actor_ctrl_chk.sv
module ea_actor_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_evt,
    input logic trig_evt,
    input logic ready,
    input logic get_input,
    input logic start_spu,
    input logic produce_output,
    input logic deadline_violation
);
    // R11: the two completion strobes are exclusive
    p_exclusive_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({produce_output, deadline_violation}));

    // R11: a launch strobe never repeats in the next cycle
    p_single_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (get_input || start_spu) |=> !(get_input || start_spu));

    // R11: a completion strobe never repeats in the next cycle
    p_single_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (produce_output || deadline_violation) |=> !(produce_output || deadline_violation));

    // R3 / R4 / R6: results are only published while the compute unit is ready
    p_publish_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        produce_output |-> ready);

    // R2 / R5: a launch is always caused by a start or trigger event in that cycle
    p_launch_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        get_input |-> (start_evt || trig_evt));

endmodule

bind ea_actor_ctrl ea_actor_ctrl_chk u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .start_evt          (start_evt),
    .trig_evt           (trig_evt),
    .ready              (ready),
    .get_input          (get_input),
    .start_spu          (start_spu),
    .produce_output     (produce_output),
    .deadline_violation (deadline_violation)
);

// File: tb/tb_ea_actor_ctrl.sv
`timescale 1ns/1ps
module tb_ea_actor_ctrl;
    localparam int DL_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic            start_evt = 1'b0;
    logic            trig_evt = 1'b0;
    logic            ready = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic [DL_W-1:0] deadline = '0;
    logic            get_input, start_spu, produce_output, deadline_violation;

    int n_run = 0;
    int n_fail = 0;

    // Reference model state: 0 idle, 1 bounded wait, 2 free wait, 3 armed, 4 hold
    int m_st = 0;
    int m_cnt = 0;
    int m_lim = 0;

    always #5 clk = ~clk;

    ea_actor_ctrl #(.DL_W(DL_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_evt(start_evt),
        .trig_evt(trig_evt), .ready(ready), .mode(mode), .deadline(deadline),
        .get_input(get_input), .start_spu(start_spu),
        .produce_output(produce_output), .deadline_violation(deadline_violation)
    );

    // One cycle: drive at the falling edge, predict and compare just before
    // the rising edge, then advance the model on the rising edge.
    task automatic step(input string tag, input logic s, input logic t,
                        input logic r, input logic k);
        logic e_gi, e_pr, e_dv, hit;
        int   nst;
        start_evt = s; trig_evt = t; ready = r; tick = k;
        #4;
        e_gi = 1'b0; e_pr = 1'b0; e_dv = 1'b0; nst = m_st;
        hit = k && ((m_cnt + 1) >= m_lim);
        case (m_st)
            0: if (s) begin
                   if (mode == 2'b00) begin e_gi = 1'b1; nst = 1; end
                   else if (mode == 2'b10) nst = 3;
                   else begin e_gi = 1'b1; nst = 2; end
               end
            1, 4: if (hit) begin
                   if (r) e_pr = 1'b1; else e_dv = 1'b1;
                   nst = 0;
               end
            2: if (r) begin e_pr = 1'b1; nst = 0; end
            3: if (hit) begin e_dv = 1'b1; nst = 0; end
               else if (t) begin e_gi = 1'b1; nst = 4; end
            default: nst = 0;
        endcase
        n_run++;
        if (get_input !== e_gi || start_spu !== e_gi ||
            produce_output !== e_pr || deadline_violation !== e_dv) begin
            n_fail++;
            $display("FAIL %s: got gi=%b spu=%b po=%b dv=%b, expected gi=%b spu=%b po=%b dv=%b",
                     tag, get_input, start_spu, produce_output, deadline_violation,
                     e_gi, e_gi, e_pr, e_dv);
        end
        @(posedge clk);
        if (m_st == 0 && s) begin
            m_cnt = 0;
            m_lim = int'(deadline);
        end else if (k && m_cnt < 255) begin
            m_cnt = m_cnt + 1;
        end
        m_st = nst;
        @(negedge clk);
    endtask

    task automatic idle_n(input string tag, input int n, input logic k);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 1'b0, k);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, then an immediate start is taken
        step("R1 reset quiet", 1'b0, 1'b0, 1'b1, 1'b1);
        mode = 2'b01; deadline = 8'd5;
        step("R1 first start accepted", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R4 free completes", 1'b0, 1'b0, 1'b1, 1'b0);

        // R2 R3: bounded, tick every cycle, ready rises early
        mode = 2'b00; deadline = 8'd3;
        step("R2 bounded launch", 1'b1, 1'b0, 1'b0, 1'b1);
        step("R3 count 1", 1'b0, 1'b0, 1'b1, 1'b1);
        step("R3 count 2", 1'b0, 1'b0, 1'b1, 1'b1);
        step("R3 publish at deadline", 1'b0, 1'b0, 1'b1, 1'b1);
        idle_n("R3 back idle", 2, 1'b1);

        // R3: bounded, ready stays low -> miss
        step("R2 bounded launch 2", 1'b1, 1'b0, 1'b0, 1'b0);
        idle_n("R3 miss path", 5, 1'b1);

        // R3 R8 R9: sparse ticks, busy start ignored, changes mid-run
        deadline = 8'd4;
        step("R9 launch d4", 1'b1, 1'b0, 1'b0, 1'b0);
        deadline = 8'd1; mode = 2'b10;
        for (int i = 0; i < 12; i++)
            step("R8 busy start/trig ignored, R9 capture", (i == 3), (i == 5), (i > 6), (i % 2 == 1));
        mode = 2'b00;

        // R4: free mode, ready in launch cycle not seen, late ready
        mode = 2'b11;
        step("R4 launch with ready", 1'b1, 1'b0, 1'b1, 1'b1);
        step("R4 ready seen next", 1'b0, 1'b0, 1'b1, 1'b1);
        mode = 2'b01;
        step("R4 launch", 1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step("R4 late ready", 1'b0, 1'b0, (i == 4), 1'b1);

        // R5 R6: terminal, trigger after two ticks, ready at deadline
        mode = 2'b10; deadline = 8'd5;
        step("R5 arm no strobe", 1'b1, 1'b0, 1'b0, 1'b1);
        step("R5 armed", 1'b0, 1'b0, 1'b0, 1'b1);
        step("R5 trigger launches", 1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step("R6 hold until deadline", 1'b0, (i == 0), (i >= 2), 1'b1);
        // R6: terminal, not ready at deadline
        step("R5 arm 2", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R5 trigger 2", 1'b0, 1'b1, 1'b0, 1'b0);
        idle_n("R6 miss after trigger", 7, 1'b1);

        // R7: no trigger, and trigger coinciding with expiry
        deadline = 8'd2;
        step("R7 arm", 1'b1, 1'b0, 1'b1, 1'b0);
        idle_n("R7 expiry before trigger", 3, 1'b1);
        step("R7 arm 2", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R7 tick 1", 1'b0, 1'b0, 1'b0, 1'b1);
        step("R7 trigger at expiry ignored", 1'b0, 1'b1, 1'b1, 1'b1);
        step("R8 late trigger in idle ignored", 1'b0, 1'b1, 1'b1, 1'b1);

        // R10: zero deadline in bounded and terminal modes
        deadline = 8'd0; mode = 2'b00;
        step("R10 bounded launch", 1'b1, 1'b0, 1'b1, 1'b1);
        step("R10 no tick", 1'b0, 1'b0, 1'b1, 1'b0);
        step("R10 first tick expires", 1'b0, 1'b0, 1'b1, 1'b1);
        mode = 2'b10;
        step("R10 terminal arm", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R10 terminal first tick", 1'b0, 1'b1, 1'b0, 1'b1);

        // R11: back-to-back runs, strobes never overlap or stretch
        mode = 2'b01;
        for (int i = 0; i < 8; i++) step("R11 back-to-back", (i % 2 == 0), 1'b0, (i % 2 == 1), 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule